// File: doc/BRIEF.md
# Packet-Hold Output Arbiter and Merge

This block sits in front of one output channel of a torus network node. Up to three input routers may want that channel at the same moment. The block gives the channel to exactly one of them and keeps it with that input for the whole packet. Ownership ends only after the end-of-packet flit has been accepted downstream. While an input owns the channel, the block merges its flits onto the single output bus. The downstream ready is passed back to the owner alone.

The arbiter is built from a two-input cell. The cell is a synchronous stand-in for a mutual-exclusion element, and it uses a deterministic round-robin tie-break. A two-input build uses one cell. The three-input build is a two-level tree: inputs 0 and 1 meet at a leaf cell, and the leaf result meets input 2 at the root cell. Both levels stay locked for the whole packet. A losing input simply holds its flit and valid until it wins a later arbitration.

Top module: `pkt_hold_arb`

## Requirements
- R1: No more than one input is granted the channel in any cycle, so no more than one bit of `inReady` is ever high.
- R2: With no packet in progress and exactly one input valid, that input is granted in the same cycle. Its flit appears on `outFlit` and its `inReady` follows `outReady` in that cycle.
- R3: A flit is 5 bits wide. Bit 4 marks end of packet. Bits 3:0 carry a one-hot data value: 0001 means 00, 0010 means 01, 0100 means 10, 1000 means 11. Ownership covers every flit up to and including the one with bit 4 set. It ends in the cycle after that flit is accepted (owner valid and `outReady` high).
- R4: `outFlit` is the bitwise OR of all input flits, each gated by its own grant and valid. When no granted input is valid, `outFlit` is all zero and `outValid` is low.
- R5: `inReady` of the owner equals `outReady`. Every other input sees `inReady` low.
- R6: When both sides of a two-input cell request while the cell is unlocked, the cell picks the side that did not win its previous grant. Under continuous contention the two sides therefore alternate packet by packet.
- R7: A waiting input keeps its flit. Every flit offered on an input reaches the output exactly once and in its original order.
- R8: In the three-input build, a packet keeps both the leaf and the root cell locked until its end flit. The output stream is then a sequence of whole packets, never interleaved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_IN | Per-input flit valid |
| reqFlit | input | NUM_IN*FLIT_W | Per-input flits, input i in bits [i*FLIT_W +: FLIT_W] |
| inReady | output | NUM_IN | Per-input accept, high only for the owner |
| outValid | output | 1 | Merged flit valid |
| outFlit | output | FLIT_W | Merged flit |
| outReady | input | 1 | Downstream accept |

## Verification
Two things can fall in the same cycle. The end flit of the current owner can be accepted while other inputs are already waiting with new packet heads. And a fresh arbitration between simultaneous heads can coincide with `outReady` dropping. Both are provoked by keeping every input loaded with back-to-back packets while `outReady` is randomly withheld. Directed contention phases pit inputs 0 and 1 against each other at the leaf, and inputs 1 and 2 at the root. Each accepted flit is judged against the bench's own per-input queue. Every packet start must come from an input other than the previous winner whenever such a rival was waiting, and no packet may begin before the previous one has ended.

// File: rtl/pha_pkg.sv
package pha_pkg;
  localparam int PHA_MAX_IN = 3;

  // Control-to-datapath strobes: one grant line per possible input.
  typedef struct packed {
    logic [PHA_MAX_IN-1:0] sel;
  } phaStrobe_t;
endpackage

// File: rtl/pha_cell2.sv
// Two-input arbitration cell with packet lock and round-robin tie-break.
module pha_cell2 (
  input  logic clk,
  input  logic rstN,
  input  logic en,       // this cell's result is granted upstream
  input  logic reqA,
  input  logic reqB,
  input  logic relEop,   // end flit accepted through the granted path
  output logic gntA,
  output logic gntB
);
  logic locked, ownB, lastB, pickB;

  always_comb begin
    if (locked)              pickB = ownB;
    else if (reqA && reqB)   pickB = !lastB;
    else                     pickB = reqB;
    gntA = locked ? !ownB : (reqA && !pickB);
    gntB = locked ?  ownB : (reqB &&  pickB);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked <= 1'b0;
      ownB   <= 1'b0;
      lastB  <= 1'b1;
    end else if (en && (gntA || gntB)) begin
      lastB  <= pickB;
      ownB   <= pickB;
      locked <= !relEop;
    end
  end

  p_lone_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && reqA && !reqB) |-> gntA);
  p_keep_owner_r3: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !(en && relEop)) |=> (locked && $stable(ownB)));
  p_rr_tie_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && reqA && reqB) |-> (gntB == !lastB));
endmodule

// File: rtl/pha_ctrl.sv
module pha_ctrl
  import pha_pkg::*;
#(
  parameter int NUM_IN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] reqValid,
  input  logic [NUM_IN-1:0] eopIn,
  input  logic              outReady,
  output phaStrobe_t        strobe
);
  logic [PHA_MAX_IN-1:0] gnt;
  logic                  xferEop;

  assign xferEop = outReady && |(gnt[NUM_IN-1:0] & reqValid & eopIn);

  generate
    if (NUM_IN == 2) begin : g_two
      pha_cell2 u_root (
        .clk(clk), .rstN(rstN), .en(1'b1),
        .reqA(reqValid[0]), .reqB(reqValid[1]), .relEop(xferEop),
        .gntA(gnt[0]), .gntB(gnt[1]));
      assign gnt[2] = 1'b0;
    end else begin : g_tree
      logic leafWin, rootB;
      pha_cell2 u_root (
        .clk(clk), .rstN(rstN), .en(1'b1),
        .reqA(reqValid[0] || reqValid[1]), .reqB(reqValid[2]),
        .relEop(xferEop), .gntA(leafWin), .gntB(rootB));
      logic leafA, leafB;
      pha_cell2 u_leaf (
        .clk(clk), .rstN(rstN), .en(leafWin),
        .reqA(reqValid[0]), .reqB(reqValid[1]), .relEop(xferEop),
        .gntA(leafA), .gntB(leafB));
      assign gnt[0] = leafWin && leafA;
      assign gnt[1] = leafWin && leafB;
      assign gnt[2] = rootB;
    end
  endgenerate

  always_comb strobe.sel = gnt;

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.sel));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((|strobe.sel) && !xferEop) |=> (strobe.sel == $past(strobe.sel)));
endmodule

// File: rtl/pha_merge.sv
module pha_merge
  import pha_pkg::*;
#(
  parameter int NUM_IN = 3,
  parameter int FLIT_W = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  phaStrobe_t               strobe,
  input  logic [NUM_IN-1:0]        reqValid,
  input  logic [NUM_IN*FLIT_W-1:0] reqFlit,
  input  logic                     outReady,
  output logic [NUM_IN-1:0]        inReady,
  output logic                     outValid,
  output logic [FLIT_W-1:0]        outFlit
);
  logic [NUM_IN-1:0] live;

  always_comb begin
    live    = strobe.sel[NUM_IN-1:0] & reqValid;
    outFlit = '0;
    for (int i = 0; i < NUM_IN; i++)
      outFlit = outFlit | (reqFlit[i*FLIT_W +: FLIT_W] & {FLIT_W{live[i]}});
    outValid = |live;
    inReady  = strobe.sel[NUM_IN-1:0] & {NUM_IN{outReady}};
  end

  p_ready_owner_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((inReady & ~strobe.sel[NUM_IN-1:0]) == '0) && (outReady || inReady == '0));
  p_idle_out_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sel == '0) |-> (!outValid && outFlit == '0));
endmodule

// File: rtl/pkt_hold_arb.sv
module pkt_hold_arb
  import pha_pkg::*;
#(
  parameter int NUM_IN = 3,
  parameter int FLIT_W = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_IN-1:0]        reqValid,
  input  logic [NUM_IN*FLIT_W-1:0] reqFlit,
  output logic [NUM_IN-1:0]        inReady,
  output logic                     outValid,
  output logic [FLIT_W-1:0]        outFlit,
  input  logic                     outReady
);
  localparam int EOP_BIT = FLIT_W - 1;

  phaStrobe_t        strobe;
  logic [NUM_IN-1:0] eopIn;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_eop
    assign eopIn[i] = reqFlit[i*FLIT_W + EOP_BIT];
  end

  pha_ctrl #(.NUM_IN(NUM_IN)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .eopIn(eopIn),
    .outReady(outReady), .strobe(strobe));

  pha_merge #(.NUM_IN(NUM_IN), .FLIT_W(FLIT_W)) u_merge (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqValid(reqValid),
    .reqFlit(reqFlit), .outReady(outReady), .inReady(inReady),
    .outValid(outValid), .outFlit(outFlit));
endmodule

// File: tb/pkt_hold_arb_bench.sv
module pkt_hold_arb_bench;
  localparam int PERIOD = 10;
  localparam int N = 3;
  localparam int W = 5;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [N-1:0]   reqValid = '0;
  logic [N*W-1:0] reqFlit = '0;
  logic [N-1:0]   inReady;
  logic           outValid;
  logic [W-1:0]   outFlit;
  logic           outReady = 1'b0;

  pkt_hold_arb #(.NUM_IN(N), .FLIT_W(W)) u_pkt_hold_arb (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqFlit(reqFlit),
    .inReady(inReady), .outValid(outValid), .outFlit(outFlit),
    .outReady(outReady));

  always #(PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  logic [W-1:0] mem [N][64];
  int len [N];
  int ptr [N];
  int curSrc = -1, lastSrc = -1, outCount = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] dataFlit();
    return W'(1 << ($urandom % 4));
  endfunction

  task automatic loadPackets(input int i, input int pkts, input int maxData);
    len[i] = 0; ptr[i] = 0;
    for (int p = 0; p < pkts; p++) begin
      int nd = 2 + ((maxData > 0) ? ($urandom % (maxData + 1)) : 0);
      for (int k = 0; k < nd; k++) begin mem[i][len[i]] = dataFlit(); len[i]++; end
      mem[i][len[i]] = 5'b10000; len[i]++;
    end
  endtask

  task automatic runPhase(input bit rrPhase, input string tag);
    int cyc = 0, expCount = 0;
    outCount = 0; lastSrc = -1;
    for (int i = 0; i < N; i++) expCount += len[i];
    while (1) begin
      bit pend = (curSrc >= 0);
      for (int i = 0; i < N; i++) if (ptr[i] < len[i]) pend = 1;
      if (!pend) break;
      if (cyc > 5000) begin chk(0, "watchdog", cyc, 5000); break; end
      cyc++;
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        reqValid[i] = (ptr[i] < len[i]);
        reqFlit[i*W +: W] = reqValid[i] ? mem[i][ptr[i]] : '0;
      end
      outReady = rrPhase ? 1'b1 : (($urandom % 4) != 0);
      #1;
      chk($countones(inReady) <= 1, "R1 one grant", inReady, 0);
      chk(outReady || inReady == '0, "R5 ready only with outReady", inReady, 0);
      if (curSrc < 0 && $countones(reqValid) == 1 && outReady)
        chk(inReady == reqValid, "R2 lone request granted at once", inReady, reqValid);
      if (curSrc >= 0 && outReady)
        chk(inReady[curSrc] == 1'b1, "R3 owner keeps channel", inReady, 1 << curSrc);
      if (!outValid) chk(outFlit == '0, "R4 idle output zero", outFlit, 0);
      if (outValid && outReady) begin
        int s = -1;
        for (int i = 0; i < N; i++) if (inReady[i]) s = i;
        chk(s >= 0 && reqValid[s], "R5 ready to a valid owner", inReady, 0);
        if (s >= 0) begin
          chk(outFlit == mem[s][ptr[s]], "R4 merged flit", outFlit, mem[s][ptr[s]]);
          if (curSrc >= 0)
            chk(s == curSrc, "R8 no interleave", s, curSrc);
          else if (lastSrc >= 0) begin
            bit rival = 0;
            for (int i = 0; i < N; i++) if (i != lastSrc && reqValid[i]) rival = 1;
            if (rival) chk(s != lastSrc, {"R6 alternation ", tag}, s, lastSrc);
          end
          if (curSrc < 0) lastSrc = s;
          curSrc = mem[s][ptr[s]][W-1] ? -1 : s;
          ptr[s]++;
          outCount++;
        end
      end
    end
    chk(outCount == expCount, {"R7 flit count ", tag}, outCount, expCount);
    for (int i = 0; i < N; i++) chk(ptr[i] == len[i], "R7 all flits drained", ptr[i], len[i]);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk(outValid == 1'b0 && outFlit == '0, "R4 reset output", outFlit, 0);
    chk(inReady == '0, "R5 reset ready", inReady, 0);
    rstN = 1'b1;
    // Lone requester on input 2
    for (int i = 0; i < N; i++) begin len[i] = 0; ptr[i] = 0; end
    loadPackets(2, 1, 1);
    runPhase(1'b1, "lone");
    // Leaf contention: inputs 0 and 1
    loadPackets(0, 3, 0); loadPackets(1, 3, 0); len[2] = 0; ptr[2] = 0;
    runPhase(1'b1, "leaf");
    // Root contention: inputs 1 and 2
    len[0] = 0; ptr[0] = 0; loadPackets(1, 3, 1); loadPackets(2, 3, 1);
    runPhase(1'b1, "root");
    // Random overlapping packets on all inputs with stalls
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < N; i++) loadPackets(i, 6, 4);
      runPhase(1'b0, "random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule